// File: doc/BRIEF.md
# Serial Output Port Expander (I2C Slave)

This block is an I2C slave that owns an eight-bit output register driving eight port pins. The master writes a byte and all eight outputs change together. There is no register pointer, so every data byte in a write replaces the whole output byte. A read does not return the register contents. It returns the levels actually present on the pins, which reach the block through a separate eight-bit readback input. The block captures these pin levels during each acknowledge bit that leads into a data byte.

SCL and SDA arrive already synchronised to the system clock. The block drives SDA through an open-drain enable: a 1 pulls the line low. The upper three address bits are fixed at 1,0,1. The four lower bits, and the byte loaded into the outputs at power-on reset, come from an external address decoder. A separate active-low bus reset abandons whatever transaction is in progress and leaves the outputs untouched.

Top module: `oex_port_expander`

## Requirements
- R1: While `rst_n` is low, and after it is released, `port_q` holds the value on `pwr_dflt` and `sda_oe` is 0 (SDA released).
- R2: The first byte after a START carries a 7-bit address, MSB first, followed by R/W (0 = write, 1 = read). The slave pulls SDA low in the ninth clock only when address bits 6..4 are 1,0,1 and bits 3..0 equal `addr_lo`. On any other address, SDA stays released for the rest of the transaction and `port_q` does not change.
- R3: After a matching write address, each data byte (MSB first) is acknowledged. `port_q` takes the new byte before SCL rises for that ninth clock.
- R4: In a write with several data bytes, each byte replaces all eight outputs. The last complete byte before STOP remains in `port_q`.
- R5: After a matching read address, `pin_rd` is captured at the SCL rising edge of the address acknowledge clock. The captured value is shifted out MSB first, and changes on `pin_rd` after that edge do not alter the byte.
- R6: When the master acknowledges (SDA low) a read byte, `pin_rd` is captured again at that ninth clock's rising edge. The next byte carries the fresh capture.
- R7: When the master does not acknowledge (SDA high) a read byte, the slave keeps SDA released on all further clocks until a STOP or START.
- R8: A START seen at any point, including a repeated START in the middle of a byte, restarts address reception. The transaction that follows it behaves as a new one.
- R9: Driving `bus_rst_n` low abandons the transaction and releases SDA within two clocks. `port_q` keeps its value, and the next transaction that begins with a START works normally.
- R10: After a STOP, SCL pulses without a new START are ignored: SDA stays released and `port_q` does not change.
- R11: START (SDA falling while SCL high) and STOP (SDA rising while SCL high) are the only bus conditions. SDA changes while SCL is low are data and never end a transfer. The slave changes its own SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset; loads the default output byte |
| bus_rst_n | input | 1 | Active-low bus reset; abandons the transaction, keeps outputs |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data line level |
| sda_oe | output | 1 | Open-drain pull-down enable for SDA (1 = drive low) |
| addr_lo | input | 4 | Low four address bits from the address decoder |
| pwr_dflt | input | 8 | Power-on default output byte from the address decoder |
| pin_rd | input | 8 | Actual pin levels used for readback |
| port_q | output | 8 | Output register driving the port pins |

## Verification
A wrong bit counter or phase state shows at the ports within one byte time. The acknowledge lands on the wrong clock, data bits slip by one position, or `port_q` takes a shifted byte at the ninth clock. A snapshot taken at the wrong moment shows up as a read byte that follows a `pin_rd` change made after the acknowledge edge, and this is visible on the first data byte. A state that survives STOP, NACK or the bus reset shows as SDA pulled low, or as an output update, during clocks that carry no START. The bench drives exactly those clocks immediately after the event.

// File: rtl/oex_pkg.sv
package oex_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,   // no transaction for this slave
      ST_ADDR,   // receiving address + R/W
      ST_AACK,   // slave acknowledging its address
      ST_WDAT,   // receiving a write byte
      ST_WACK,   // slave acknowledging a write byte
      ST_RDAT,   // slave shifting out a read byte
      ST_RACK,   // master acknowledge slot after a read byte
      ST_SKIP    // released until next START or STOP
   } oex_state_e;
endpackage

// File: rtl/oex_bus_cond.sv
module oex_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise  = scl_i & ~scl_q;
   assign scl_fall  = ~scl_i & scl_q;
   assign start_det = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/oex_port_reg.sv
module oex_port_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] dflt,
   input  logic              ld,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= dflt;
      else if (ld) q <= d;
   end
endmodule

// File: rtl/oex_slave_fsm.sv
module oex_slave_fsm
   import oex_pkg::*;
#(
   parameter int                  DATA_W       = 8,
   parameter int                  ADDR_LO_W    = 4,
   parameter int                  ADDR_PFX_W   = 3,
   parameter logic [ADDR_PFX_W-1:0] ADDR_PFX   = 3'b101,
   parameter bit                  SNAP_ON_RISE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_rst_n,
   input  logic                 scl_i,
   input  logic                 sda_i,
   input  logic                 scl_rise,
   input  logic                 scl_fall,
   input  logic                 start_det,
   input  logic                 stop_det,
   input  logic [ADDR_LO_W-1:0] addr_lo,
   input  logic [DATA_W-1:0]    pin_rd,
   output logic                 sda_oe,
   output logic                 wr_stb,
   output logic [DATA_W-1:0]    wr_data
);
   localparam int BCNT_W = $clog2(DATA_W + 1);
   localparam logic [BCNT_W-1:0] BYTE_END = BCNT_W'(DATA_W);

   oex_state_e        state_q;
   logic [BCNT_W-1:0] bcnt_q;
   logic [DATA_W-1:0] rx_q, tx_q, snap_q;
   logic              rw_q, mack_q, oe_q;
   logic              byte_end, addr_hit, snap_take, live;

   assign byte_end = (bcnt_q == BYTE_END);
   assign addr_hit = (rx_q[DATA_W-1:1] == {ADDR_PFX, addr_lo});
   assign live     = bus_rst_n & ~start_det & ~stop_det;
   assign wr_stb   = live & scl_fall & byte_end & (state_q == ST_WDAT);
   assign wr_data  = rx_q;
   assign sda_oe   = oe_q;

   // Moment of the pin capture: rising SCL inside the ack clock, or the
   // falling edge that opens it.
   generate
      if (SNAP_ON_RISE) begin : g_snap_rise
         assign snap_take = live & scl_rise &
                            (((state_q == ST_AACK) & rw_q) |
                             ((state_q == ST_RACK) & ~sda_i));
      end else begin : g_snap_fall
         assign snap_take = live & scl_fall & byte_end &
                            (((state_q == ST_ADDR) & addr_hit & rx_q[0]) |
                             (state_q == ST_RDAT));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)         snap_q <= '0;
      else if (snap_take) snap_q <= pin_rd;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !bus_rst_n) begin
         state_q <= ST_IDLE;
         bcnt_q  <= '0;
         oe_q    <= 1'b0;
         rw_q    <= 1'b0;
         mack_q  <= 1'b0;
         rx_q    <= '0;
         tx_q    <= '0;
      end else if (start_det) begin
         state_q <= ST_ADDR;
         bcnt_q  <= '0;
         oe_q    <= 1'b0;
      end else if (stop_det) begin
         state_q <= ST_IDLE;
         oe_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_ADDR, ST_WDAT: begin
               if (scl_rise && !byte_end) begin
                  rx_q   <= {rx_q[DATA_W-2:0], sda_i};
                  bcnt_q <= bcnt_q + 1'b1;
               end
               if (scl_fall && byte_end) begin
                  if (state_q == ST_WDAT) begin
                     state_q <= ST_WACK;
                     oe_q    <= 1'b1;
                  end else if (addr_hit) begin
                     state_q <= ST_AACK;
                     oe_q    <= 1'b1;
                     rw_q    <= rx_q[0];
                  end else begin
                     state_q <= ST_SKIP;
                  end
               end
            end
            ST_AACK: begin
               if (scl_fall) begin
                  bcnt_q <= '0;
                  if (rw_q) begin
                     state_q <= ST_RDAT;
                     tx_q    <= snap_q;
                     oe_q    <= ~snap_q[DATA_W-1];
                  end else begin
                     state_q <= ST_WDAT;
                     oe_q    <= 1'b0;
                  end
               end
            end
            ST_WACK: begin
               if (scl_fall) begin
                  state_q <= ST_WDAT;
                  bcnt_q  <= '0;
                  oe_q    <= 1'b0;
               end
            end
            ST_RDAT: begin
               if (scl_rise) begin
                  bcnt_q <= bcnt_q + 1'b1;
                  tx_q   <= tx_q << 1;
               end
               if (scl_fall) begin
                  if (byte_end) begin
                     state_q <= ST_RACK;
                     oe_q    <= 1'b0;
                  end else begin
                     oe_q <= ~tx_q[DATA_W-1];
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) mack_q <= ~sda_i;
               if (scl_fall) begin
                  if (mack_q) begin
                     state_q <= ST_RDAT;
                     bcnt_q  <= '0;
                     tx_q    <= snap_q;
                     oe_q    <= ~snap_q[DATA_W-1];
                  end else begin
                     state_q <= ST_SKIP;
                     oe_q    <= 1'b0;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   // R11: own drive changes only on edges taken while SCL was low
   p_oe_still_scl_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(scl_i) && $past(bus_rst_n) &&
       !$past(start_det) && !$past(stop_det)) |-> $stable(oe_q));
   p_addr_ack_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_AACK) |-> oe_q);
   p_wr_ack_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> (state_q == ST_WACK) && oe_q);
   p_bcnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bcnt_q <= BYTE_END);
   p_skip_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SKIP) |-> !oe_q);
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> !oe_q);
endmodule

// File: rtl/oex_port_expander.sv
module oex_port_expander #(
   parameter int                    DATA_W       = 8,
   parameter int                    ADDR_LO_W    = 4,
   parameter int                    ADDR_PFX_W   = 3,
   parameter logic [ADDR_PFX_W-1:0] ADDR_PFX     = 3'b101,
   parameter bit                    SNAP_ON_RISE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_rst_n,
   input  logic                 scl_i,
   input  logic                 sda_i,
   output logic                 sda_oe,
   input  logic [ADDR_LO_W-1:0] addr_lo,
   input  logic [DATA_W-1:0]    pwr_dflt,
   input  logic [DATA_W-1:0]    pin_rd,
   output logic [DATA_W-1:0]    port_q
);
   localparam int ADDR_W = ADDR_PFX_W + ADDR_LO_W;

   generate
      if (ADDR_W != 7) begin : g_bad_addr
         $error("address prefix plus low bits must form a 7-bit address");
      end
      if (DATA_W != ADDR_W + 1) begin : g_bad_data
         $error("data width must equal one address byte");
      end
   endgenerate

   logic scl_rise, scl_fall, start_det, stop_det;
   logic wr_stb;
   logic [DATA_W-1:0] wr_data;

   oex_bus_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   oex_slave_fsm #(
      .DATA_W       (DATA_W),
      .ADDR_LO_W    (ADDR_LO_W),
      .ADDR_PFX_W   (ADDR_PFX_W),
      .ADDR_PFX     (ADDR_PFX),
      .SNAP_ON_RISE (SNAP_ON_RISE)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_rst_n (bus_rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .addr_lo   (addr_lo),
      .pin_rd    (pin_rd),
      .sda_oe    (sda_oe),
      .wr_stb    (wr_stb),
      .wr_data   (wr_data)
   );

   oex_port_reg #(.DATA_W(DATA_W)) u_port (
      .clk   (clk),
      .rst_n (rst_n),
      .dflt  (pwr_dflt),
      .ld    (wr_stb),
      .d     (wr_data),
      .q     (port_q)
   );

   // R9: a bus reset never disturbs the outputs
   p_busrst_hold_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rst_n |=> $stable(port_q));
   // R11: the slave never pulls SDA while a START or STOP is being seen
   p_no_drive_on_cond_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det || stop_det) |-> !sda_oe);
endmodule

// File: tb/oex_port_expander_bench.sv
module oex_port_expander_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_rst_n = 1'b1;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic       sda_oe;
   logic [3:0] addr_lo = 4'h9;
   logic [7:0] pwr_dflt = 8'hA5;
   logic [7:0] pin_rd = 8'h00;
   logic [7:0] port_q;
   logic       sda_line;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   localparam logic [7:0] WR_ADDR = 8'hB2; // 1011001 + W
   localparam logic [7:0] RD_ADDR = 8'hB3; // 1011001 + R

   always #10 clk = ~clk;
   assign sda_line = m_sda & ~sda_oe;

   oex_port_expander u_oex_port_expander (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_rst_n (bus_rst_n),
      .scl_i     (m_scl),
      .sda_i     (sda_line),
      .sda_oe    (sda_oe),
      .addr_lo   (addr_lo),
      .pwr_dflt  (pwr_dflt),
      .pin_rd    (pin_rd),
      .port_q    (port_q)
   );

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; waitc(4);
      m_scl = 1'b1; waitc(4);
      m_sda = 1'b0; waitc(4);
      m_scl = 1'b0; waitc(2);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; waitc(4);
      m_scl = 1'b1; waitc(4);
      m_sda = 1'b1; waitc(6);
   endtask

   // one clock; SDA is wiggled while SCL is low before settling (R11)
   task automatic clk_bit(input logic b, output logic seen);
      m_sda = ~b; waitc(2);
      m_sda = b;  waitc(2);
      m_scl = 1'b1; waitc(4);
      seen = sda_line;
      waitc(4);
      m_scl = 1'b0; waitc(2);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
      clk_bit(1'b1, s);
      ack = ~s;
   endtask

   task automatic recv_byte(input logic m_ack, output logic [7:0] v);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         v[i] = s;
      end
      clk_bit(~m_ack, s);
   endtask

   task automatic t_reset();
      waitc(3);
      chk("R1", "port during reset", port_q, 8'hA5);
      rst_n = 1'b1; waitc(4);
      chk("R1", "port after reset", port_q, 8'hA5);
      chk("R1", "sda released", {7'b0, sda_oe}, 8'h00);
   endtask

   task automatic t_write_single();
      logic a;
      bus_start();
      send_byte(WR_ADDR, a); chk("R2", "write address ack", {7'b0, a}, 8'h01);
      send_byte(8'h3C, a);   chk("R3", "data ack", {7'b0, a}, 8'h01);
      chk("R3", "port after byte", port_q, 8'h3C);
      bus_stop();
      chk("R3", "port after stop", port_q, 8'h3C);
   endtask

   task automatic t_write_multi();
      logic a;
      logic [7:0] vals [3] = '{8'h55, 8'hAA, 8'h0F};
      bus_start();
      send_byte(WR_ADDR, a);
      foreach (vals[i]) begin
         send_byte(vals[i], a);
         chk("R4", "multi byte ack", {7'b0, a}, 8'h01);
         chk("R4", "multi byte port", port_q, vals[i]);
      end
      bus_stop();
      chk("R11", "data toggles kept transfer alive", port_q, 8'h0F);
   endtask

   task automatic t_wrong_addr();
      logic a;
      bus_start();
      send_byte(8'hB4, a); chk("R2", "low bits mismatch nack", {7'b0, a}, 8'h00);
      send_byte(8'hE1, a); chk("R2", "no ack on data", {7'b0, a}, 8'h00);
      chk("R2", "port kept", port_q, 8'h0F);
      bus_stop();
      bus_start();
      send_byte(8'hD2, a); chk("R2", "prefix 110 nack", {7'b0, a}, 8'h00);
      send_byte(8'h00, a);
      chk("R2", "port kept after prefix mismatch", port_q, 8'h0F);
      bus_stop();
   endtask

   task automatic t_read();
      logic a, s;
      logic [7:0] v;
      pin_rd = 8'h96;
      bus_start();
      send_byte(RD_ADDR, a); chk("R5", "read address ack", {7'b0, a}, 8'h01);
      pin_rd = 8'h11;
      recv_byte(1'b1, v);    chk("R5", "first byte is ack snapshot", v, 8'h96);
      pin_rd = 8'hC3;
      recv_byte(1'b0, v);    chk("R6", "second byte resampled", v, 8'h11);
      pin_rd = 8'h00;
      v = 8'h00;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         v[i] = s;
      end
      chk("R7", "released after nack", v, 8'hFF);
      bus_stop();
   endtask

   task automatic t_rep_start();
      logic a, s;
      bus_start();
      send_byte(WR_ADDR, a);
      send_byte(8'h77, a);
      chk("R8", "port before restart", port_q, 8'h77);
      clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
      bus_start();
      send_byte(WR_ADDR, a); chk("R8", "address ack after restart", {7'b0, a}, 8'h01);
      send_byte(8'h88, a);
      chk("R8", "port after restart write", port_q, 8'h88);
      bus_stop();
   endtask

   task automatic t_bus_reset();
      logic a, s;
      bus_start();
      send_byte(WR_ADDR, a);
      for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
      bus_rst_n = 1'b0; waitc(3); bus_rst_n = 1'b1;
      chk("R9", "port kept on bus reset", port_q, 8'h88);
      pin_rd = 8'h00;
      bus_start();
      send_byte(RD_ADDR, a);
      clk_bit(1'b1, s); clk_bit(1'b1, s);
      chk("R9", "slave driving before reset", {7'b0, s}, 8'h00);
      bus_rst_n = 1'b0; waitc(2);
      chk("R9", "sda released by bus reset", {7'b0, sda_oe}, 8'h00);
      waitc(1); bus_rst_n = 1'b1;
      chk("R9", "port kept after read abort", port_q, 8'h88);
      bus_start();
      send_byte(WR_ADDR, a); chk("R9", "ack after bus reset", {7'b0, a}, 8'h01);
      send_byte(8'h42, a);
      bus_stop();
      chk("R9", "write after bus reset", port_q, 8'h42);
   endtask

   task automatic t_after_stop();
      logic a;
      send_byte(WR_ADDR, a); chk("R10", "no ack without start", {7'b0, a}, 8'h00);
      send_byte(8'hEE, a);   chk("R10", "no ack on data", {7'b0, a}, 8'h00);
      chk("R10", "port unchanged", port_q, 8'h42);
      bus_stop();
   endtask

   initial begin
      t_reset();
      t_write_single();
      t_write_multi();
      t_wrong_addr();
      t_read();
      t_rep_start();
      t_bus_reset();
      t_after_stop();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule